// File: doc/BRIEF.md
# Watchdog Timer with Assignable Postscaler

This block is the watchdog of a small microcontroller core. A base counter advances on a clock-enable tick from the slow watchdog oscillator. After a parameterised number of ticks it produces a base time-out. One 8-bit divider is shared between the watchdog and a general-purpose timer. When the divider serves the watchdog, it stretches the base time-out by a power-of-two ratio. When it serves the timer, it prescales the timer's count pulses, and the watchdog runs at its base period.

Software restarts the watchdog with a clear strobe, which models the clear-watchdog instruction. A sleep strobe restarts it in the same way and also puts the core to sleep. A time-out while the core is awake requests a device reset. A time-out while asleep requests a wake-up instead. Either kind of time-out drops an active-high "no time-out" status flag to 0.

All pins are plain control and status lines. Nothing flows through the block as a stream, so there is no valid/ready interface. The core clock and the watchdog tick enable are synchronous.

Top module: `wdt_postscale_top`

## Requirements
- R1: After reset, `rst_req` and `wake_req` are 0, `tmr_inc` is 0, and `no_tmo` is 1.
- R2: While the divider is assigned to the timer (`div_to_wdt`=0), the watchdog times out after `BASE_TICKS` ticks counted from a clear. The reset request appears in the cycle after the last tick.
- R3: While the divider is assigned to the watchdog (`div_to_wdt`=1), the time-out comes after `BASE_TICKS * 2**ratio_sel` ticks. `ratio_sel`=3'b000 is 1:1 and 3'b111 is 1:128.
- R4: A clear strobe restarts the base counter and sets `no_tmo` to 1. It also empties the divider, but only when the divider is assigned to the watchdog.
- R5: A time-out while awake gives a `rst_req` pulse one cycle wide and drives `no_tmo` to 0.
- R6: A sleep strobe restarts the watchdog in the same way as a clear and puts the block into sleep. A time-out while asleep gives a one-cycle `wake_req` with no `rst_req`, drives `no_tmo` to 0, and ends the sleep. The next time-out is then a reset.
- R7: While `wdt_en` is 0, no time-out occurs and the base counter is held at zero. After `wdt_en` is set, a full period elapses before the first time-out.
- R8: If the divider is assigned to the watchdog and `ratio_sel` is lowered without a clear, so that the divider count exceeds the new terminal count, a time-out fires at once and `rst_req` is seen in the next cycle. If a clear comes first, the full new period applies.
- R9: A change of `div_to_wdt` takes effect only on the next watchdog tick, and the divider count is emptied at that moment.
- R10: While the divider is assigned to the timer, `tmr_inc` pulses for one cycle in the cycle after every `2**ratio_sel`-th `tmr_tick`. Clear strobes do not disturb this count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on reset |
| wdt_tick | input | 1 | Watchdog oscillator clock enable |
| wdt_en | input | 1 | Configuration enable for the watchdog |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Sleep strobe; restarts the watchdog and enters sleep |
| div_to_wdt | input | 1 | Divider assignment: 1 = watchdog, 0 = timer |
| ratio_sel | input | 3 | Divider ratio, 1:2**ratio_sel |
| tmr_tick | input | 1 | Timer source pulse fed to the divider when assigned to the timer |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| no_tmo | output | 1 | Status flag; 0 after a watchdog time-out |
| tmr_inc | output | 1 | Prescaled timer increment pulse |

## Verification
The bench measures the tick distance to the reset request for several ratio and assignment pairs. A design that decodes the ratio wrongly, or that fails to bypass the divider while it serves the timer, shows up as a count that is off by a factor. It lowers the ratio with a half-filled divider both without and with a preceding clear. A design that compares only for equality would miss the immediate time-out, and one that ignores the clear would fire early. It also switches the divider assignment with no tick present and then feeds timer pulses. A design that switches at once, or that keeps the old count, produces a timer increment at the wrong pulse. The sleep and disable sequences catch a reset request issued instead of a wake-up, and a counter that keeps running while disabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DIV_W = 8;
  localparam int PS_W  = 3;

  typedef enum logic {
    DIV_OWNER_TMR = 1'b0,
    DIV_OWNER_WDT = 1'b1
  } div_owner_e;

  function automatic logic [DIV_W-1:0] ratio_term(input logic [PS_W-1:0] sel);
    logic [DIV_W:0] one_hot;
    one_hot = (DIV_W+1)'(1) << sel;
    return DIV_W'(one_hot - (DIV_W+1)'(1));
  endfunction
endpackage

// File: rtl/wdt_base_timer.sv
module wdt_base_timer #(
  parameter int BASE_TICKS = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic restart,
  output logic base_ovf
);
  localparam int CW = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign base_ovf = en && tick && !restart && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!en || restart)   cnt_q <= '0;
    else if (tick)             cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end

  initial begin
    if (BASE_TICKS < 2) $error("BASE_TICKS must be at least 2");
  end

  // R2
  base_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7
  base_held_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_shared_divider.sv
module wdt_shared_divider
  import wdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            owner_req,
  input  logic [PS_W-1:0] ratio_sel,
  input  logic            wdt_pulse,
  input  logic            tmr_pulse,
  input  logic            wdt_restart,
  input  logic            wdt_en,
  output logic            wdt_fire,
  output logic            tmr_fire,
  output logic            owner_wdt
);
  div_owner_e             owner_q;
  logic [DIV_W-1:0]       cnt_q;
  logic [DIV_W-1:0]       term;
  logic                   reassign;
  logic                   in_pulse;
  logic                   active;
  logic                   flush;
  logic                   fire;

  assign owner_wdt = (owner_q == DIV_OWNER_WDT);
  assign term      = ratio_term(ratio_sel);
  assign reassign  = tick && (owner_req != owner_wdt);
  assign in_pulse  = owner_wdt ? wdt_pulse : tmr_pulse;
  assign active    = owner_wdt ? wdt_en : 1'b1;
  assign flush     = reassign || (owner_wdt && (wdt_restart || !wdt_en));
  assign fire      = active && !flush &&
                     ((cnt_q > term) || (in_pulse && (cnt_q == term)));
  assign wdt_fire  = fire && owner_wdt;
  assign tmr_fire  = fire && !owner_wdt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= DIV_OWNER_WDT;
      cnt_q   <= '0;
    end else begin
      if (reassign) owner_q <= owner_req ? DIV_OWNER_WDT : DIV_OWNER_TMR;
      if (flush || fire) cnt_q <= '0;
      else if (in_pulse) cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // R9
  owner_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != $past(owner_q)) |-> $past(tick));

  // R9
  reassign_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reassign |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_event_ctrl.sv
module wdt_event_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic clr,
  input  logic sleep,
  output logic rst_req,
  output logic wake_req,
  output logic no_tmo
);
  logic asleep_q;
  logic restart;
  logic tmo_ok;

  assign restart = clr || sleep;
  assign tmo_ok  = timeout && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      no_tmo   <= 1'b1;
      asleep_q <= 1'b0;
    end else begin
      rst_req  <= tmo_ok && !asleep_q;
      wake_req <= tmo_ok && asleep_q;
      if (restart)     no_tmo <= 1'b1;
      else if (timeout) no_tmo <= 1'b0;
      if (sleep)                   asleep_q <= 1'b1;
      else if (tmo_ok && asleep_q) asleep_q <= 1'b0;
    end
  end

  // R6
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req));

  // R5
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R5
  rst_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !no_tmo);

  // R6
  wake_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ($past(asleep_q) && !no_tmo && !asleep_q));
endmodule

// File: rtl/wdt_postscale_top.sv
module wdt_postscale_top
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wdt_tick,
  input  logic            wdt_en,
  input  logic            clr_wdt,
  input  logic            sleep_cmd,
  input  logic            div_to_wdt,
  input  logic [PS_W-1:0] ratio_sel,
  input  logic            tmr_tick,
  output logic            rst_req,
  output logic            wake_req,
  output logic            no_tmo,
  output logic            tmr_inc
);
  logic restart;
  logic base_ovf;
  logic wdt_fire;
  logic tmr_fire;
  logic owner_wdt;
  logic timeout;

  assign restart = clr_wdt || sleep_cmd;

  wdt_base_timer #(.BASE_TICKS(BASE_TICKS)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (wdt_en),
    .tick     (wdt_tick),
    .restart  (restart),
    .base_ovf (base_ovf)
  );

  wdt_shared_divider u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (wdt_tick),
    .owner_req   (div_to_wdt),
    .ratio_sel   (ratio_sel),
    .wdt_pulse   (base_ovf),
    .tmr_pulse   (tmr_tick),
    .wdt_restart (restart),
    .wdt_en      (wdt_en),
    .wdt_fire    (wdt_fire),
    .tmr_fire    (tmr_fire),
    .owner_wdt   (owner_wdt)
  );

  assign timeout = owner_wdt ? wdt_fire : base_ovf;

  wdt_event_ctrl u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .timeout  (timeout),
    .clr      (clr_wdt),
    .sleep    (sleep_cmd),
    .rst_req  (rst_req),
    .wake_req (wake_req),
    .no_tmo   (no_tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_inc <= 1'b0;
    else        tmr_inc <= tmr_fire;
  end

  // R7
  off_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wdt_en) |-> !rst_req);

  // R10
  tmr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_inc |-> $past(tmr_tick));
endmodule

// File: tb/tb_wdt_postscale_top.sv
module tb_wdt_postscale_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 18;
  localparam int NVEC = 5;
  localparam bit VEC_OWN [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int VEC_PS  [NVEC] = '{0, 1, 3, 5, 7};
  localparam int VEC_EXP [NVEC] = '{BASE, BASE*2, BASE*8, BASE, BASE*128};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_tick = 1'b0, wdt_en = 1'b1, clr_wdt = 1'b0, sleep_cmd = 1'b0;
  logic div_to_wdt = 1'b1, tmr_tick = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic rst_req, wake_req, no_tmo, tmr_inc;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_postscale_top #(.BASE_TICKS(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .wdt_en(wdt_en),
    .clr_wdt(clr_wdt), .sleep_cmd(sleep_cmd), .div_to_wdt(div_to_wdt),
    .ratio_sel(ratio_sel), .tmr_tick(tmr_tick), .rst_req(rst_req),
    .wake_req(wake_req), .no_tmo(no_tmo), .tmr_inc(tmr_inc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe_clr();
    @(negedge clk); wdt_tick = 1'b0; clr_wdt = 1'b1;
    @(negedge clk); clr_wdt = 1'b0;
  endtask

  task automatic apply_owner(input bit own, input int ps);
    @(negedge clk); div_to_wdt = own; ratio_sel = 3'(ps); wdt_tick = 1'b1;
    @(negedge clk); wdt_tick = 1'b0;
  endtask

  // ticks every cycle until a request pulse; returns ticks elapsed
  task automatic run_ticks(input int limit, output int n, output bit got_rst, output bit got_wake);
    n = 0; got_rst = 0; got_wake = 0;
    wdt_tick = 1'b1;
    while (n < limit) begin
      @(negedge clk); n++;
      if (rst_req || wake_req) begin
        got_rst = rst_req; got_wake = wake_req;
        break;
      end
    end
    wdt_tick = 1'b0;
  endtask

  task automatic pulse_tmr(output bit inc);
    @(negedge clk); tmr_tick = 1'b1;
    @(negedge clk); tmr_tick = 1'b0; inc = tmr_inc;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n; bit gr, gw, inc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rst_req && !wake_req && !tmr_inc, "R1", {rst_req, wake_req, tmr_inc}, 0);
    chk(no_tmo == 1'b1, "R1", no_tmo, 1);
    rst_n = 1'b1;

    // R2/R3 vector table
    for (int v = 0; v < NVEC; v++) begin
      apply_owner(VEC_OWN[v], VEC_PS[v]);
      strobe_clr();
      chk(no_tmo == 1'b1, "R4", no_tmo, 1);
      run_ticks(VEC_EXP[v] + 4, n, gr, gw);
      chk(gr && n == VEC_EXP[v], VEC_OWN[v] ? "R3" : "R2", n, VEC_EXP[v]);
      chk(no_tmo == 1'b0, "R5", no_tmo, 0);
      @(negedge clk);
      chk(rst_req == 1'b0, "R5", rst_req, 0);
    end

    // R8 hazard: lower ratio with half-filled divider, no clear
    apply_owner(1'b1, 7);
    strobe_clr();
    run_ticks(BASE*5 - 1, n, gr, gw);
    chk(!gr && n == BASE*5 - 1, "R8", n, BASE*5 - 1);
    @(negedge clk); ratio_sel = 3'd1;
    @(negedge clk);
    chk(rst_req == 1'b1, "R8", rst_req, 1);
    // R8 safe: clear first
    apply_owner(1'b1, 7);
    strobe_clr();
    run_ticks(BASE*5 - 1, n, gr, gw);
    strobe_clr();
    ratio_sel = 3'd1;
    @(negedge clk);
    chk(rst_req == 1'b0, "R8", rst_req, 0);
    run_ticks(BASE*2 + 4, n, gr, gw);
    chk(gr && n == BASE*2, "R8", n, BASE*2);

    // R6 sleep then wake
    apply_owner(1'b0, 1);
    @(negedge clk); sleep_cmd = 1'b1;
    @(negedge clk); sleep_cmd = 1'b0;
    chk(no_tmo == 1'b1, "R6", no_tmo, 1);
    run_ticks(BASE + 4, n, gr, gw);
    chk(gw && !gr && n == BASE, "R6", n, BASE);
    chk(no_tmo == 1'b0, "R6", no_tmo, 0);
    run_ticks(BASE + 4, n, gr, gw);
    chk(gr && !gw && n == BASE, "R6", {gr, gw}, 2);

    // R7 disabled
    strobe_clr();
    wdt_en = 1'b0;
    run_ticks(BASE*3, n, gr, gw);
    chk(!gr && !gw, "R7", gr, 0);
    wdt_en = 1'b1;
    run_ticks(BASE + 4, n, gr, gw);
    chk(gr && n == BASE, "R7", n, BASE);

    // R9 reassignment waits for a tick and empties the divider
    apply_owner(1'b1, 3);
    strobe_clr();
    run_ticks(BASE*3, n, gr, gw);
    @(negedge clk); div_to_wdt = 1'b0;
    inc = 0;
    for (int k = 0; k < 8; k++) begin
      bit i1; pulse_tmr(i1); inc |= i1;
    end
    chk(inc == 1'b0, "R9", inc, 0);
    @(negedge clk); wdt_tick = 1'b1;
    @(negedge clk); wdt_tick = 1'b0;
    inc = 0;
    for (int k = 0; k < 7; k++) begin
      bit i1; pulse_tmr(i1); inc |= i1;
    end
    chk(inc == 1'b0, "R9", inc, 0);
    pulse_tmr(inc);
    chk(inc == 1'b1, "R9", inc, 1);
    @(negedge clk);
    chk(tmr_inc == 1'b0, "R10", tmr_inc, 0);

    // R10 prescale 1:4, clear does not disturb the timer count
    ratio_sel = 3'd2;
    pulse_tmr(inc); pulse_tmr(inc);
    strobe_clr();
    pulse_tmr(inc);
    chk(inc == 1'b0, "R10", inc, 0);
    pulse_tmr(inc);
    chk(inc == 1'b1, "R10", inc, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule